// File: doc/BRIEF.md
# Six-Step Brushless Motor Commutation Generator

This block produces the six gate-drive levels for a three-phase half-bridge. Each of the phases U, V and W has a high-side switch and a low-side switch. An external divider supplies a slow tick enable, and every timing quantity in the block is counted in those ticks.

In static mode the block walks through the six commutation states. It moves one state per motor period, and a direction input decides whether the state index goes up or down. In chopped mode the same sequence is used, but the active high-side switch is gated by a duty compare against the count within the current period. Two further features protect the bridge. A programmable blanking window holds all switches off after each commutation step and after drive resumes. A brake input, which is active low, overrides everything and turns on all three low sides.

Top module: `bldc_sixstep`

## Requirements
- R1: `gateOut` bit order is 0 = U high, 1 = U low, 2 = V high, 3 = V low, 4 = W high, 5 = W low. The step patterns are: step 0 = 0x09 (U+ V-), step 1 = 0x21 (U+ W-), step 2 = 0x24 (V+ W-), step 3 = 0x06 (V+ U-), step 4 = 0x12 (W+ U-), step 5 = 0x18 (W+ V-). With `dirCw`=1 the step index counts up and wraps from 5 to 0.
- R2: With `dirCw`=0 the step index counts down and wraps from 0 to 5.
- R3: The step advances on the tick that completes `periodTicks` ticks within the current interval. A period of 0 behaves as a period of 1, so the step advances on every tick.
- R4: In mode 1 (chopped), the active high-side switch is on only while the intra-period tick count (0 at the start of an interval) is below `dutyCmp`. The low-side switch stays on for the whole interval. Mode 0 never chops.
- R5: Mode values 2 and 3 drive all six outputs low and freeze the sequence.
- R6: After each step advance, and after drive resumes from disable or brake, all six outputs stay low for `deadTicks` ticks of the period count.
- R7: While `brakeN` is low, `gateOut` is 0x2A and `brakeActive` is 1 from the next clock edge. This holds regardless of enable or mode. The step and the period count are frozen during braking.
- R8: While `enable` is low (and there is no brake), all outputs are low, and the step index and period count return to 0.
- R9: A change of `dirCw` within an interval does not alter the current step. It takes effect at the next advance.
- R10: No phase ever has both its high and low switch on, including during reset. Reset leaves every output low with the step at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow tick enable, one clock wide |
| enable | input | 1 | Drive enable |
| mode | input | 2 | 0 static, 1 chopped, others off |
| dirCw | input | 1 | 1 counts steps up, 0 counts down |
| deadTicks | input | DEAD_W | Blanking window in ticks |
| periodTicks | input | PERIOD_W | Ticks per commutation interval |
| dutyCmp | input | PERIOD_W | High-side on-count in chopped mode |
| brakeN | input | 1 | Active-low brake request |
| gateOut | output | 6 | Gate levels, order as in R1 |
| brakeActive | output | 1 | 1 while braking |

## Verification
The bench builds the block with the default widths: a 16-bit period and duty, and a 4-bit blanking count. It then drives tiny period values of 0, 2, 3 and 4 ticks with a duty of 1. These small values make every step wrap in both directions, both halves of a chopped interval and the period-zero edge case reachable in a few dozen ticks. A blanking count of 2 against a period of 4 leaves both blank and driven ticks within a single interval, both after an advance and after a resume.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  localparam int unsigned NUM_STEPS = 6;
  localparam logic [5:0] LOW_SIDE_MASK = 6'b101010;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_CHOP   = 2'd1,
    MODE_RSV2   = 2'd2,
    MODE_RSV3   = 2'd3
  } driveMode_e;

  typedef struct packed {
    logic advance;    // step boundary reached on this tick
    logic dirCw;      // direction to use for the advance
    logic clearStep;  // drive disabled: return step to zero
    logic loadBlank;  // reload blanking counter
    logic decBlank;   // tick inside an interval: count blanking down
    logic chopOn;     // high side may conduct this cycle
    logic driveOk;    // enabled, not braking, valid mode
  } ctrlStrobe_t;

  function automatic logic [5:0] stepGates(input logic [2:0] s);
    case (s)
      3'd0:    return 6'h09;
      3'd1:    return 6'h21;
      3'd2:    return 6'h24;
      3'd3:    return 6'h06;
      3'd4:    return 6'h12;
      3'd5:    return 6'h18;
      default: return 6'h00;
    endcase
  endfunction

endpackage

// File: rtl/bldc_ctrl.sv
module bldc_ctrl
  import bldc_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                enable,
  input  logic                brakeN,
  input  logic [1:0]          mode,
  input  logic                dirCw,
  input  logic [PERIOD_W-1:0] periodTicks,
  input  logic [PERIOD_W-1:0] dutyCmp,
  output ctrlStrobe_t         strb
);

  localparam int unsigned EXT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] perCnt;
  logic                modeValid;
  logic                driveOk;
  logic                atEnd;

  assign modeValid = (mode == MODE_STATIC) || (mode == MODE_CHOP);
  assign driveOk   = enable && brakeN && modeValid;
  // a zero period compares as "end reached" on every tick
  assign atEnd = ({1'b0, perCnt} + EXT_W'(1)) >= {1'b0, periodTicks};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perCnt <= '0;
    end else if (!enable) begin
      perCnt <= '0;
    end else if (driveOk && tickEn) begin
      perCnt <= atEnd ? '0 : perCnt + PERIOD_W'(1);
    end
  end

  always_comb begin
    strb.driveOk   = driveOk;
    strb.dirCw     = dirCw;
    strb.advance   = driveOk && tickEn && atEnd;
    strb.clearStep = !enable;
    strb.loadBlank = !driveOk || (tickEn && atEnd);
    strb.decBlank  = driveOk && tickEn && !atEnd;
    strb.chopOn    = (mode == MODE_STATIC) || (perCnt < dutyCmp);
  end

  // R8
  disabled_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |=> (perCnt == '0));

  // R7
  brake_freezes_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!brakeN && enable) |=> $stable(perCnt));

endmodule

// File: rtl/bldc_datapath.sv
module bldc_datapath
  import bldc_pkg::*;
#(
  parameter int unsigned DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              brakeN,
  input  logic [DEAD_W-1:0] deadTicks,
  output logic [5:0]        gateOut,
  output logic              brakeActive
);

  localparam logic [2:0] LAST_STEP = 3'(NUM_STEPS - 1);

  logic [2:0]        stepIdx;
  logic [DEAD_W-1:0] blankCnt;
  logic [5:0]        gateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strb.clearStep) begin
      stepIdx <= '0;
    end else if (strb.advance) begin
      if (strb.dirCw) stepIdx <= (stepIdx == LAST_STEP) ? 3'd0 : stepIdx + 3'd1;
      else            stepIdx <= (stepIdx == 3'd0) ? LAST_STEP : stepIdx - 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strb.loadBlank) begin
      blankCnt <= deadTicks;
    end else if (strb.decBlank && (blankCnt != '0)) begin
      blankCnt <= blankCnt - DEAD_W'(1);
    end
  end

  always_comb begin
    if (!brakeN) begin
      gateNext = LOW_SIDE_MASK;
    end else if (!strb.driveOk || (blankCnt != '0)) begin
      gateNext = '0;
    end else begin
      gateNext = stepGates(stepIdx) & (strb.chopOn ? 6'h3F : LOW_SIDE_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateOut     <= '0;
      brakeActive <= 1'b0;
    end else begin
      gateOut     <= gateNext;
      brakeActive <= !brakeN;
    end
  end

  // R10
  no_shoot_through_chk: assert property (@(posedge clk)
    (gateOut & (gateOut >> 1) & 6'b010101) == 6'b0);

  // R1
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < 3'(NUM_STEPS));

  // R7
  brake_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!brakeN) |=> (gateOut == LOW_SIDE_MASK && brakeActive));

  // R6
  blank_keeps_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brakeN && blankCnt != '0) |=> (gateOut == 6'b0));

  // R9
  step_only_on_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clearStep) |=> $stable(stepIdx));

endmodule

// File: rtl/bldc_sixstep.sv
module bldc_sixstep
  import bldc_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned DEAD_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic                dirCw,
  input  logic [DEAD_W-1:0]   deadTicks,
  input  logic [PERIOD_W-1:0] periodTicks,
  input  logic [PERIOD_W-1:0] dutyCmp,
  input  logic                brakeN,
  output logic [5:0]          gateOut,
  output logic                brakeActive
);

  ctrlStrobe_t strb;

  bldc_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .enable      (enable),
    .brakeN      (brakeN),
    .mode        (mode),
    .dirCw       (dirCw),
    .periodTicks (periodTicks),
    .dutyCmp     (dutyCmp),
    .strb        (strb)
  );

  bldc_datapath #(.DEAD_W(DEAD_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .brakeN      (brakeN),
    .deadTicks   (deadTicks),
    .gateOut     (gateOut),
    .brakeActive (brakeActive)
  );

  // R8
  disabled_outputs_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && brakeN) |=> (gateOut == 6'b0));

endmodule

// File: tb/tb_bldc_sixstep.sv
module tb_bldc_sixstep;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dirCw = 1'b1;
  logic [3:0]  deadTicks = 4'd0;
  logic [15:0] periodTicks = 16'd2;
  logic [15:0] dutyCmp = 16'd1;
  logic        brakeN = 1'b1;
  logic [5:0]  gateOut;
  logic        brakeActive;

  int testsRun = 0;
  int testsFailed = 0;
  bit shootSeen = 1'b0;

  always #2.5 clk = ~clk;

  bldc_sixstep dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .enable(enable), .mode(mode),
    .dirCw(dirCw), .deadTicks(deadTicks), .periodTicks(periodTicks),
    .dutyCmp(dutyCmp), .brakeN(brakeN), .gateOut(gateOut),
    .brakeActive(brakeActive)
  );

  typedef struct packed {
    logic       dir;
    logic [1:0] md;
    logic [1:0] nTicks;
    logic [5:0] expGates;
  } vec_t;

  // period 2, duty 1, blanking 0
  localparam vec_t VECS [15] = '{
    '{1'b1, 2'd0, 2'd0, 6'h09},  // R1 step 0
    '{1'b1, 2'd0, 2'd1, 6'h09},  // R3 mid interval
    '{1'b1, 2'd0, 2'd1, 6'h21},  // R1 step 1
    '{1'b1, 2'd0, 2'd2, 6'h24},
    '{1'b1, 2'd0, 2'd2, 6'h06},
    '{1'b1, 2'd0, 2'd2, 6'h12},
    '{1'b1, 2'd0, 2'd2, 6'h18},
    '{1'b1, 2'd0, 2'd2, 6'h09},  // R1 wrap 5->0
    '{1'b0, 2'd0, 2'd1, 6'h09},  // R9 direction held mid interval
    '{1'b0, 2'd0, 2'd1, 6'h18},  // R2 wrap 0->5
    '{1'b0, 2'd0, 2'd2, 6'h12},  // R2
    '{1'b0, 2'd1, 2'd0, 6'h12},  // R4 count 0 < duty
    '{1'b0, 2'd1, 2'd1, 6'h02},  // R4 chopped, low side kept
    '{1'b0, 2'd1, 2'd1, 6'h06},  // R4 next step
    '{1'b0, 2'd2, 2'd0, 6'h00}   // R5
  };

  always @(negedge clk)
    if ((gateOut & (gateOut >> 1) & 6'b010101) != 6'b0) shootSeen = 1'b1;

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic checkGates(input string req, input logic [5:0] exp);
    check(req, {1'b0, gateOut}, {1'b0, exp});
  endtask

  task automatic doTick();
    @(negedge clk) tickEn = 1'b1;
    @(negedge clk) tickEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic resetDut(input logic en, input logic [3:0] dead, input logic [15:0] per);
    @(negedge clk);
    rstN = 1'b0; enable = en; deadTicks = dead; periodTicks = per;
    dutyCmp = 16'd1; mode = 2'd0; dirCw = 1'b1; brakeN = 1'b1; tickEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
  endtask

  initial begin
    #1_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset", {brakeActive, gateOut}, 7'h00);

    resetDut(1'b1, 4'd0, 16'd2);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      dirCw = VECS[i].dir;
      mode  = VECS[i].md;
      for (int t = 0; t < int'(VECS[i].nTicks); t++) doTick();
      settle();
      checkGates($sformatf("R1/R2/R4/R5/R9 vector %0d", i), VECS[i].expGates);
    end

    // R3 zero period advances every tick
    resetDut(1'b1, 4'd0, 16'd0);
    doTick(); settle(); checkGates("R3 period0 first", 6'h21);
    doTick(); settle(); checkGates("R3 period0 second", 6'h24);

    // R3 period of three
    resetDut(1'b1, 4'd0, 16'd3);
    doTick(); doTick(); settle(); checkGates("R3 period3 held", 6'h09);
    doTick(); settle(); checkGates("R3 period3 advance", 6'h21);

    // R6 blanking after resume and after advance
    resetDut(1'b0, 4'd2, 16'd4);
    @(negedge clk) enable = 1'b1;
    settle(); checkGates("R6 resume blank", 6'h00);
    doTick(); settle(); checkGates("R6 resume blank tick1", 6'h00);
    doTick(); settle(); checkGates("R6 resume drive", 6'h09);
    doTick(); settle();
    doTick(); settle(); checkGates("R6 advance blank", 6'h00);
    doTick(); settle(); checkGates("R6 advance blank tick1", 6'h00);
    doTick(); settle(); checkGates("R6 advance drive", 6'h21);

    // R7 brake timing, freeze, release
    resetDut(1'b1, 4'd0, 16'd2);
    doTick(); doTick(); settle();
    checkGates("R7 pre-brake step1", 6'h21);
    @(negedge clk) brakeN = 1'b0;
    @(negedge clk);
    check("R7 brake next edge", {brakeActive, gateOut}, 7'h6A);
    repeat (3) doTick();
    settle();
    check("R7 brake held", {brakeActive, gateOut}, 7'h6A);
    @(negedge clk) brakeN = 1'b1;
    settle();
    check("R7 release frozen step", {brakeActive, gateOut}, 7'h21);
    @(negedge clk) begin enable = 1'b0; brakeN = 1'b0; end
    settle();
    check("R7 brake overrides disable", {brakeActive, gateOut}, 7'h6A);
    @(negedge clk) brakeN = 1'b1;

    // R8 disable clears step
    resetDut(1'b1, 4'd0, 16'd2);
    repeat (4) doTick();
    settle(); checkGates("R8 running step2", 6'h24);
    @(negedge clk) enable = 1'b0;
    settle(); checkGates("R8 disabled off", 6'h00);
    @(negedge clk) enable = 1'b1;
    settle(); checkGates("R8 step back to 0", 6'h09);
    doTick(); settle(); checkGates("R8 count cleared", 6'h09);

    // R10 no shoot-through seen across the run
    check("R10 no shoot-through", {6'b0, shootSeen}, 7'h00);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule